// File: doc/BRIEF.md
# Stereo Audio Transmit Queue

This block is a small stereo sample queue that sits between a processor or DMA write port and an audio serializer. Each slot carries one left and one right sample. Software or a DMA engine fills the queue through a write-only window. The window takes either one full word that carries both channels, or two halfword writes (left at the base address, right at base+2) that are joined into one slot. Byte writes are refused. Reading the window always returns zero.

On the serializer side the queue presents one stereo pair on a valid/ready interface. A pair moves when `out_valid` and `out_ready` are both high at a rising clock edge. While `out_ready` is low, the presented pair stays put. Output is gated by a fill state. When `run` is low, or when playback has drained the queue completely, the block holds `out_valid` low until every slot is occupied again. A low-water refill alone does not restart output.

Fill-level flags drive one interrupt line. Software chooses the interrupt mode with three enable pins: all slots free, at least half free, or at least one free. Two DMA request outputs both follow the at-least-one-free condition. A write that arrives while the queue is full is discarded and sets a sticky overflow flag.

Top module: `stereo_txq`

## Requirements
- R1: A write with `wr_size`=2 (word) and `wr_hi`=0 stores one slot: left sample from `wr_data[15:0]`, right sample from `wr_data[31:16]`.
- R2: A write with `wr_size`=1 (halfword) takes its sample from `wr_data[15:0]`. With `wr_hi`=0 it is the left half and with `wr_hi`=1 the right half. No slot is stored until both halves are present.
- R3: A right half that arrives with no left half pending is held, and the next left half completes the pair. A second left half written before any right half replaces the first.
- R4: Writes with `wr_size`=0 (byte) or 3, and word writes with `wr_hi`=1, change nothing.
- R5: After `run` rises, `out_valid` stays low until four slots are stored. It goes high one cycle after the fourth slot is stored.
- R6: When playback empties the queue, `out_valid` stays low while it refills, until all four slots are stored again.
- R7: Pairs leave in write order, one per cycle in which `out_valid` and `out_ready` are both high. While `out_ready` is low, `out_valid` and the pair hold.
- R8: A slot offered while four are stored is dropped, and `overflow` goes high and stays high until reset.
- R9: `rd_data` is always zero.
- R10: `dma_req0` and `dma_req1` are both high exactly while fewer than four slots are stored.
- R11: `irq` is high while (`ie_whole` and no slot stored) or (`ie_half` and at least two slots free) or (`ie_one` and at least one slot free).
- R12: After reset the queue is empty, `out_valid` and `overflow` are low, and both DMA requests are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| run | input | 1 | Playback enable; low forces the fill state |
| wr_en | input | 1 | Write strobe for the sample window |
| wr_hi | input | 1 | 0 selects the base address, 1 selects base+2 |
| wr_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data of the window, always zero |
| out_valid | output | 1 | Stereo pair available to the serializer |
| out_ready | input | 1 | Serializer takes the pair |
| out_left | output | 16 | Left sample of the head slot |
| out_right | output | 16 | Right sample of the head slot |
| ie_whole | input | 1 | Interrupt on all slots free |
| ie_half | input | 1 | Interrupt on at least half the slots free |
| ie_one | input | 1 | Interrupt on at least one slot free |
| irq | output | 1 | Interrupt request level |
| dma_req0 | output | 1 | DMA request, first channel |
| dma_req1 | output | 1 | DMA request, second channel |
| overflow | output | 1 | Sticky flag for a dropped write |

## Verification
A write becomes a stored slot at the clock edge that captures it, so `dma_req0/1` and `irq` change at that same edge. `out_valid` rises one edge later, because the fill state is registered. A pop takes effect at the edge where valid and ready are both high. The bench changes inputs 1 ns after a falling edge and samples outputs 5 ns after a falling edge, which is just before the rising edge that acts on them. It therefore checks the fill-state delay by sampling once before that extra edge and once after it. A monitor compares every handshaked pair against a queue of the slots the driver expects to be accepted.

// File: rtl/stereo_txq_pkg.sv
package stereo_txq_pkg;
  localparam int SAMPLE_W = 16;
  localparam int SLOTS    = 4;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } wr_size_e;

  typedef enum logic {
    PH_FILL = 1'b0,
    PH_PLAY = 1'b1
  } phase_e;
endpackage

// File: rtl/stereo_txq_pack.sv
module stereo_txq_pack
  import stereo_txq_pkg::*;
#(
  parameter int SW = SAMPLE_W,
  localparam int PW = 2 * SW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic          wr_hi,
  input  logic [1:0]    wr_size,
  input  logic [PW-1:0] wr_data,
  output logic          push,
  output logic [PW-1:0] push_pair
);
  logic [SW-1:0] left_q, right_q;
  logic          left_v, right_v;
  logic          word_wr, half_l, half_r;

  assign word_wr = wr_en && (wr_size == SZ_WORD) && !wr_hi;
  assign half_l  = wr_en && (wr_size == SZ_HALF) && !wr_hi;
  assign half_r  = wr_en && (wr_size == SZ_HALF) &&  wr_hi;

  always_comb begin
    push      = word_wr || (half_l && right_v) || (half_r && left_v);
    if (word_wr)     push_pair = wr_data;
    else if (half_l) push_pair = {right_q, wr_data[SW-1:0]};
    else             push_pair = {wr_data[SW-1:0], left_q};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      left_q  <= '0;
      right_q <= '0;
      left_v  <= 1'b0;
      right_v <= 1'b0;
    end else if (half_l) begin
      if (right_v) begin
        right_v <= 1'b0;
        left_v  <= 1'b0;
      end else begin
        left_q <= wr_data[SW-1:0];
        left_v <= 1'b1;
      end
    end else if (half_r) begin
      if (left_v) begin
        right_v <= 1'b0;
        left_v  <= 1'b0;
      end else begin
        right_q <= wr_data[SW-1:0];
        right_v <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/stereo_txq_ring.sv
module stereo_txq_ring
  import stereo_txq_pkg::*;
#(
  parameter int DEPTH = SLOTS,
  parameter int PW    = 2 * SAMPLE_W,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [PW-1:0] push_pair,
  input  logic          pop,
  output logic [PW-1:0] head,
  output logic [CW-1:0] count,
  output logic          overflow
);
  logic [PW-1:0] slot_q [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          full, do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && (count != '0);
  assign head    = slot_q[rp];

  function automatic logic [AW-1:0] step(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) slot_q[wp] <= push_pair;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp       <= '0;
      rp       <= '0;
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      if (do_push) wp <= step(wp);
      if (do_pop)  rp <= step(rp);
      if (do_push && !do_pop)      count <= count + 1'b1;
      else if (do_pop && !do_push) count <= count - 1'b1;
      if (push && full) overflow <= 1'b1;
    end
  end
endmodule

// File: rtl/stereo_txq_gate.sv
module stereo_txq_gate
  import stereo_txq_pkg::*;
#(
  parameter int DEPTH = SLOTS,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic [CW-1:0] count,
  output logic          playing
);
  phase_e ph_q, ph_d;

  always_comb begin
    ph_d = ph_q;
    if (!run)                                         ph_d = PH_FILL;
    else if (ph_q == PH_FILL && count == CW'(DEPTH))  ph_d = PH_PLAY;
    else if (ph_q == PH_PLAY && count == '0)          ph_d = PH_FILL;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph_q <= PH_FILL;
    else        ph_q <= ph_d;
  end

  assign playing = (ph_q == PH_PLAY);
endmodule

// File: rtl/stereo_txq_req.sv
module stereo_txq_req
  import stereo_txq_pkg::*;
#(
  parameter int DEPTH = SLOTS,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic [CW-1:0] count,
  input  logic          ie_whole,
  input  logic          ie_half,
  input  logic          ie_one,
  output logic          lvl_one,
  output logic          irq
);
  logic [CW-1:0] free_n;
  logic          lvl_whole, lvl_half;

  assign free_n    = CW'(DEPTH) - count;
  assign lvl_whole = (count == '0);
  assign lvl_half  = (free_n >= CW'((DEPTH + 1) / 2));
  assign lvl_one   = (free_n != '0);
  assign irq       = (ie_whole && lvl_whole) || (ie_half && lvl_half) || (ie_one && lvl_one);
endmodule

// File: rtl/stereo_txq.sv
module stereo_txq
  import stereo_txq_pkg::*;
#(
  parameter int DEPTH = SLOTS,
  parameter int SW    = SAMPLE_W,
  localparam int PW   = 2 * SW,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          run,
  input  logic          wr_en,
  input  logic          wr_hi,
  input  logic [1:0]    wr_size,
  input  logic [PW-1:0] wr_data,
  output logic [PW-1:0] rd_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [SW-1:0] out_left,
  output logic [SW-1:0] out_right,
  input  logic          ie_whole,
  input  logic          ie_half,
  input  logic          ie_one,
  output logic          irq,
  output logic          dma_req0,
  output logic          dma_req1,
  output logic          overflow
);
  logic          push, playing, lvl_one;
  logic [PW-1:0] push_pair, head;
  logic [CW-1:0] count;

  stereo_txq_pack #(.SW(SW)) u_pack (
    .clk, .rst_n, .wr_en, .wr_hi, .wr_size, .wr_data,
    .push, .push_pair
  );

  stereo_txq_ring #(.DEPTH(DEPTH), .PW(PW)) u_ring (
    .clk, .rst_n, .push, .push_pair,
    .pop(out_valid && out_ready),
    .head, .count, .overflow
  );

  stereo_txq_gate #(.DEPTH(DEPTH)) u_gate (
    .clk, .rst_n, .run, .count, .playing
  );

  stereo_txq_req #(.DEPTH(DEPTH)) u_req (
    .count, .ie_whole, .ie_half, .ie_one, .lvl_one, .irq
  );

  assign out_valid = run && playing && (count != '0);
  assign out_left  = head[SW-1:0];
  assign out_right = head[PW-1:SW];
  assign dma_req0  = lvl_one;
  assign dma_req1  = lvl_one;
  assign rd_data   = '0;
endmodule

// File: rtl/stereo_txq_chk.sv
module stereo_txq_chk #(
  parameter int SW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          run,
  input logic          wr_en,
  input logic          wr_hi,
  input logic [1:0]    wr_size,
  input logic          out_valid,
  input logic          out_ready,
  input logic [SW-1:0] out_left,
  input logic [SW-1:0] out_right,
  input logic          ie_whole,
  input logic          ie_half,
  input logic          ie_one,
  input logic          irq,
  input logic          dma_req0,
  input logic          dma_req1,
  input logic          overflow
);
  a_r8_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> overflow);

  a_r7_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && run) |=>
      (!run || (out_valid && $stable(out_left) && $stable(out_right))));

  a_r5_full_on_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> !dma_req0);

  a_r11_whole_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ie_whole && !ie_half && !ie_one && irq) |-> !out_valid);

  a_r10_full_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (!dma_req1 && wr_en && wr_size == 2'd2 && !wr_hi) |=> overflow);
endmodule

bind stereo_txq stereo_txq_chk #(.SW(SW)) u_chk (
  .clk, .rst_n, .run, .wr_en, .wr_hi, .wr_size, .out_valid, .out_ready,
  .out_left, .out_right, .ie_whole, .ie_half, .ie_one, .irq,
  .dma_req0, .dma_req1, .overflow
);

// File: tb/stereo_txq_tb.sv
module stereo_txq_tb;
  localparam int DEPTH = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0, wr_en = 1'b0, wr_hi = 1'b0, out_ready = 1'b0;
  logic [1:0]  wr_size = 2'd0;
  logic [31:0] wr_data = '0, rd_data;
  logic        out_valid, irq, dma_req0, dma_req1, overflow;
  logic [15:0] out_left, out_right;
  logic        ie_whole = 1'b0, ie_half = 1'b0, ie_one = 1'b0;

  always #10 clk = ~clk;

  stereo_txq u_dut (
    .clk, .rst_n, .run, .wr_en, .wr_hi, .wr_size, .wr_data, .rd_data,
    .out_valid, .out_ready, .out_left, .out_right,
    .ie_whole, .ie_half, .ie_one, .irq, .dma_req0, .dma_req1, .overflow
  );

  int          n_cmp = 0, n_bad = 0, model_cnt = 0, pops = 0;
  bit          done = 1'b0;
  logic [31:0] expq[$];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic settle;
    @(negedge clk); #5;
  endtask

  task automatic bus_wr(input logic hi, input logic [1:0] sz, input logic [31:0] d);
    @(negedge clk); #1;
    wr_en = 1'b1; wr_hi = hi; wr_size = sz; wr_data = d;
    @(posedge clk); #1;
    wr_en = 1'b0;
  endtask

  task automatic expect_push(input logic [31:0] pair);
    if (model_cnt < DEPTH) begin
      expq.push_back(pair);
      model_cnt++;
    end
  endtask

  task automatic word_wr(input logic [31:0] d);
    bus_wr(1'b0, 2'd2, d);
    expect_push(d);
  endtask

  task automatic set_ie(input logic w, input logic h, input logic o);
    @(negedge clk); #1;
    ie_whole = w; ie_half = h; ie_one = o;
  endtask

  // monitor: samples just before the edge that performs the handshake
  initial begin
    forever begin
      @(negedge clk); #5;
      if (rst_n && out_valid && out_ready) begin
        if (expq.size() == 0) begin
          chk("R7 pop with empty scoreboard", {out_right, out_left}, 32'hxxxx_xxxx);
        end else begin
          chk("R7/R1/R2/R3 pair order", {out_right, out_left}, expq.pop_front());
          model_cnt--;
          pops++;
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired before the run ended");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle;
    chk("R12 out_valid after reset", 32'(out_valid), 32'd0);
    chk("R12 overflow after reset", 32'(overflow), 32'd0);
    chk("R12 dma requests after reset", {30'd0, dma_req1, dma_req0}, 32'd3);
    chk("R9 read data zero", rd_data, 32'd0);

    @(negedge clk); #1; run = 1'b1;
    set_ie(1'b1, 1'b0, 1'b0);
    settle;
    chk("R11 whole-empty irq at zero slots", 32'(irq), 32'd1);

    word_wr(32'hB0A1_A0A1);                         // R1
    settle;
    chk("R5 no output with one slot", 32'(out_valid), 32'd0);
    chk("R11 whole-empty irq clears", 32'(irq), 32'd0);

    bus_wr(1'b0, 2'd1, 32'hFFFF_1111);              // R2 left half
    bus_wr(1'b1, 2'd1, 32'hEEEE_2222);              // R2 right half
    expect_push(32'h2222_1111);
    set_ie(1'b0, 1'b1, 1'b0);
    settle;
    chk("R11 half-empty irq at two free", 32'(irq), 32'd1);

    bus_wr(1'b0, 2'd0, 32'h1234_5678);              // R4 byte
    bus_wr(1'b1, 2'd2, 32'h1234_5678);              // R4 word at base+2
    bus_wr(1'b0, 2'd3, 32'h1234_5678);              // R4 reserved size
    settle;
    chk("R4 ignored writes leave two free", 32'(irq), 32'd1);

    bus_wr(1'b1, 2'd1, 32'h0000_3333);              // R3 right first
    settle;
    chk("R3 lone right half stores nothing", 32'(irq), 32'd1);
    bus_wr(1'b0, 2'd1, 32'h0000_4444);
    expect_push(32'h3333_4444);
    settle;
    chk("R11 half-empty irq clears at one free", 32'(irq), 32'd0);
    set_ie(1'b0, 1'b0, 1'b1);
    settle;
    chk("R11 one-empty irq at one free", 32'(irq), 32'd1);

    bus_wr(1'b0, 2'd1, 32'h0000_5555);
    settle;
    chk("R2 lone left half keeps slot free", 32'(dma_req0), 32'd1);
    bus_wr(1'b0, 2'd1, 32'h0000_6666);              // R3 overwrite
    bus_wr(1'b1, 2'd1, 32'h0000_7777);
    expect_push(32'h7777_6666);
    settle;
    chk("R10 dma drops when full", {30'd0, dma_req1, dma_req0}, 32'd0);
    chk("R5 valid waits one cycle after fill", 32'(out_valid), 32'd0);
    settle;
    chk("R5 valid once full", 32'(out_valid), 32'd1);
    chk("R11 one-empty irq low when full", 32'(irq), 32'd0);

    word_wr(32'hDEAD_BEEF);                         // R8 dropped
    settle;
    chk("R8 overflow set", 32'(overflow), 32'd1);
    settle;
    chk("R7 stall holds left", 32'(out_left), 32'h0000_A0A1);
    chk("R9 read data zero while full", rd_data, 32'd0);

    @(negedge clk); #1; out_ready = 1'b1;
    repeat (6) settle;
    chk("R6 valid low when drained", 32'(out_valid), 32'd0);
    chk("R10 dma high when drained", {30'd0, dma_req1, dma_req0}, 32'd3);
    chk("R8 overflow stays", 32'(overflow), 32'd1);

    word_wr(32'h0102_0304);
    repeat (3) settle;
    chk("R6 no restart on partial refill", 32'(out_valid), 32'd0);
    word_wr(32'h0506_0708);
    word_wr(32'h090A_0B0C);
    word_wr(32'h0D0E_0F10);
    repeat (8) settle;
    chk("R6 all refilled pairs delivered", 32'(pops), 32'd8);
    chk("R7 scoreboard empty", 32'(expq.size()), 32'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule